// File: doc/BRIEF.md
# Datapath Function Unit with Status Flags

This block is the combinational processing stage of an n-bit register datapath. It takes two operands, called Bus A and Bus B, together with a 4-bit function code, and produces a single n-bit result along with four status bits: overflow, carry, negative and zero. Inside it sit three parallel engines. The first is an adder-based arithmetic engine. The second is a bitwise logic engine. The third is a one-position shifter that works on Bus B only. An output selector passes one engine's result to the output.

The function code is split into fields that feed the engines directly. The two top bits pick the engine. When both are 1, the shifter result goes to the output. When the top bit is 0, the arithmetic engine drives the output. When the code is `10xx`, the logic engine drives it. The block holds no state and has no states or transitions. A result changes in the same cycle as its operands and code.

Top module: `fu_datapath`

## Requirements
- R1: When fs[3] and fs[2] are both 1, the output `f` comes from the shifter. For every other code, `f` comes from the ALU: the arithmetic engine when fs[3]=0, and the logic engine when fs[3:2]=10.
- R2: For arithmetic codes (fs[3]=0), `f` equals A + Y + fs[0], taken modulo 2^W. The second addend Y depends on fs[2:1]: 00 gives 0, 01 gives ~B, 10 gives B, and 11 gives all ones. So 0000 is A, 0001 is A+1, 0010 is A+~B, 0011 is A-B, 0100 is A+B, and 0111 is A.
- R3: Code 0101 gives A+B+1, and code 0110 gives A-1.
- R4: For logic codes fs[3:2]=10, the operation depends on fs[1:0]: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A.
- R5: Code 1100 passes B through unchanged. Code 1101 shifts B right by one. Code 1110 shifts B left by one. Code 1111 also passes B through. Every vacated bit is filled with 0.
- R6: `n` equals the most significant bit of `f` for every code.
- R7: `z` is 1 exactly when every bit of `f` is 0.
- R8: For arithmetic codes, `c` is the carry out of the W-bit addition A + Y + fs[0]. For logic and shift codes, `c` is 0.
- R9: For arithmetic codes, `v` is 1 exactly when A and Y have the same sign bit and the sign bit of `f` differs from it. For logic and shift codes, `v` is 0.
- R10: For shift codes, Bus A has no effect on `f`, `c`, `v`, `n` or `z`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Bus A operand |
| b | input | W | Bus B operand, also the shifter source |
| fs | input | 4 | Function code |
| f | output | W | Selected result |
| v | output | 1 | Signed overflow |
| c | output | 1 | Carry out |
| n | output | 1 | Negative (result MSB) |
| z | output | 1 | Zero detect |

## Verification
Every output is combinational, so each result and flag is due in the same cycle that the operands and the code are applied. No register stands on the path. The bench applies a new vector shortly after a rising clock edge and samples all five outputs at the following falling edge. This gives a full half period for the logic to settle and keeps sampling clear of the active edge. The sweep is exhaustive over all 16 codes and all operand pairs at a 4-bit width. For shift codes, each vector is applied a second time with Bus A inverted, and the bench compares the two sets of outputs.

// File: rtl/fu_datapath_pkg.sv
package fu_datapath_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2
    } unit_sel_e;

    function automatic unit_sel_e decode_unit(input logic [1:0] top_bits);
        unit_sel_e u;
        unique case (top_bits)
            2'b11:   u = UNIT_SHIFT;
            2'b10:   u = UNIT_LOGIC;
            default: u = UNIT_ARITH;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   gsel,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int EXT = W + 1;

    logic [W-1:0]   addend;
    logic [EXT-1:0] wide;

    always_comb begin
        unique case (gsel[2:1])
            2'b00: addend = '0;
            2'b01: addend = ~opb;
            2'b10: addend = opb;
            2'b11: addend = '1;
        endcase
    end

    assign wide = {1'b0, opa} + {1'b0, addend} + {{W{1'b0}}, gsel[0]};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (opa[W-1] == addend[W-1]) && (sum[W-1] != opa[W-1]);

    always_comb begin
        if (gsel == 3'b000) begin
            assert_pass_no_carry_R2: assert (sum == opa && !cout);
        end
        if (gsel == 3'b001 && cout) begin
            assert_incr_carry_all_ones_R8: assert (opa == '1);
        end
        if (ovf) begin
            assert_ovf_same_sign_R9: assert (opa[W-1] == addend[W-1]);
        end
    end
endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   hsel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (hsel)
            2'b00: res = opa & opb;
            2'b01: res = opa | opb;
            2'b10: res = opa ^ opb;
            2'b11: res = ~opa;
        endcase
    end

    always_comb begin
        if (hsel == 2'b00) begin
            assert_and_subset_R4: assert ((res & ~opa) == '0);
        end
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    input  logic [1:0]   hsel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (hsel)
            2'b01:   res = {1'b0, src[W-1:1]};
            2'b10:   res = {src[W-2:0], 1'b0};
            default: res = src;
        endcase
    end

    always_comb begin
        if (hsel == 2'b01) begin
            assert_right_fill_zero_R5: assert (res[W-1] == 1'b0);
        end
        if (hsel == 2'b10) begin
            assert_left_fill_zero_R5: assert (res[0] == 1'b0);
        end
        assert_ones_preserved_R5: assert ($countones(res) <= $countones(src));
    end
endmodule

// File: rtl/fu_datapath.sv
module fu_datapath
    import fu_datapath_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fs,
    output logic [W-1:0] f,
    output logic         v,
    output logic         c,
    output logic         n,
    output logic         z
);
    unit_sel_e    unit;
    logic         mf;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic         arith_c;
    logic         arith_v;

    assign mf   = fs[3] & fs[2];
    assign unit = decode_unit(fs[3:2]);

    fu_arith #(.W(W)) u_arith (
        .opa (a),
        .opb (b),
        .gsel(fs[2:0]),
        .sum (arith_res),
        .cout(arith_c),
        .ovf (arith_v)
    );

    fu_logic #(.W(W)) u_logic (
        .opa (a),
        .opb (b),
        .hsel(fs[1:0]),
        .res (logic_res)
    );

    fu_shift #(.W(W)) u_shift (
        .src (b),
        .hsel(fs[1:0]),
        .res (shift_res)
    );

    always_comb begin
        unique case (unit)
            UNIT_SHIFT: begin
                f = shift_res;
                c = 1'b0;
                v = 1'b0;
            end
            UNIT_LOGIC: begin
                f = logic_res;
                c = 1'b0;
                v = 1'b0;
            end
            default: begin
                f = arith_res;
                c = arith_c;
                v = arith_v;
            end
        endcase
    end

    assign n = f[W-1];
    assign z = (f == '0);

    always_comb begin
        if (z) begin
            assert_zero_not_negative_R7: assert (!n);
        end
        if (c || v) begin
            assert_flags_only_arith_R8: assert (!fs[3]);
        end
        if (mf) begin
            assert_shift_bits_from_b_R1: assert ($countones(f) <= $countones(b));
        end
    end
endmodule

// File: tb/fu_datapath_test.sv
module fu_datapath_test;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   fs = '0;
    logic [W-1:0] f;
    logic         v, c, n, z;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    fu_datapath #(.W(W)) uut (
        .a(a), .b(b), .fs(fs), .f(f), .v(v), .c(c), .n(n), .z(z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s fs=%b a=%h b=%h actual=%0h expected=%0h", req, what, fs, a, b, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] code, input logic [W-1:0] xa, input logic [W-1:0] xb,
                         output logic [W-1:0] ef, output logic ec, output logic ev);
        logic [W-1:0] y;
        int s;
        ec = 1'b0;
        ev = 1'b0;
        if (code[3] == 1'b0) begin
            case (code[2:1])
                2'b00: y = '0;
                2'b01: y = ~xb;
                2'b10: y = xb;
                default: y = '1;
            endcase
            s = int'(xa) + int'(y) + int'(code[0]);
            ef = s[W-1:0];
            ec = (s >= (1 << W));
            ev = (xa[W-1] == y[W-1]) && (ef[W-1] != xa[W-1]);
        end else if (code[2] == 1'b0) begin
            case (code[1:0])
                2'b00: ef = xa & xb;
                2'b01: ef = xa | xb;
                2'b10: ef = xa ^ xb;
                default: ef = ~xa;
            endcase
        end else begin
            case (code[1:0])
                2'b01: ef = xb >> 1;
                2'b10: ef = xb << 1;
                default: ef = xb;
            endcase
        end
    endtask

    task automatic req_of(input logic [3:0] code, output string r);
        if (code == 4'b0101 || code == 4'b0110) r = "R3";
        else if (!code[3]) r = "R2";
        else if (!code[2]) r = "R4";
        else r = "R5/R1";
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ef;
        logic ec, ev;
        logic [W-1:0] keep_f;
        logic keep_c, keep_v, keep_n, keep_z;
        string r;

        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7", "reset z", int'(z), 1);
        check("R2", "reset f", int'(f), 0);

        for (int k = 0; k < 16; k++) begin
            for (int ia = 0; ia < (1 << W); ia++) begin
                for (int ib = 0; ib < (1 << W); ib++) begin
                    @(posedge clk);
                    #1;
                    fs = 4'(k);
                    a  = W'(ia);
                    b  = W'(ib);
                    @(negedge clk);
                    model(fs, a, b, ef, ec, ev);
                    req_of(fs, r);
                    check(r, "f", int'(f), int'(ef));
                    check("R6", "n", int'(n), int'(ef[W-1]));
                    check("R7", "z", int'(z), int'(ef == '0));
                    check("R8", "c", int'(c), int'(ec));
                    check("R9", "v", int'(v), int'(ev));
                    if (fs[3:2] == 2'b11) begin
                        keep_f = f; keep_c = c; keep_v = v; keep_n = n; keep_z = z;
                        @(posedge clk);
                        #1;
                        a = ~a;
                        @(negedge clk);
                        check("R10", "f under A change", int'(f), int'(keep_f));
                        check("R10", "flags under A change", int'({c, v, n, z}),
                              int'({keep_c, keep_v, keep_n, keep_z}));
                    end
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule